// File: doc/BRIEF.md
# Slot Hotplug Event Controller

This block keeps track of which of a set of expansion slots hold a device, which slots are waiting for software to remove their device, and which slots may be removed at all. The slot side reports events as bit vectors: a hot insert, an insert that was already present at power-up (a cold insert), and a removal request. Each accepted hot event sets a hotplug bit in a small byte-wide event block. An event output is raised while that status bit and its matching enable bit are both set.

Software works with two windows. The first is a word-wide register window with four 32-bit registers. They report the removable slots that hold a device, the pending removals and the removable mask. A write to the eject register retires one pending removal. The second is a 4-byte event block: two write-1-to-clear status bytes followed by two read/write enable bytes. A platform reset pulse starts a drain sequence. The sequence retires every pending removal, one slot per cycle with the lowest slot first. It then rebuilds the removable mask from the non-removable strap and the present vector from the populated strap.

Top module: `hpslot_evt_ctrl`

## Requirements
- R1: After `rst_n` is released, `busy` stays high for 2 cycles. After that: the pending vector is 0, removable = ~`fixed_mask`, `slot_present` = `populated`, the event bytes read 0 and `evt_out` is 0.
- R2: Register reads with `reg_sel`=1 and `reg_we`=0 return the following. Offset 0x0 gives present AND removable. Offset 0x4 gives the pending vector. Offset 0x8 gives 0. Offset 0xC gives the removable vector. With no read in progress, `reg_rdata` is 0.
- R3: Only full-word accesses count, meaning `reg_be`=4'hF and `reg_addr[1:0]`=0. Any other read returns 0, and any other write has no effect.
- R4: A hot insert on slot n (`ins_req[n]`=1, `ins_cold[n]`=0) sets present bit n and sets bit 1 of event byte 0 at the next edge. A cold insert (`ins_cold[n]`=1) sets present bit n and leaves the status unchanged.
- R5: A removal request on slot n (`rem_req[n]`=1) sets pending bit n and bit 1 of event byte 0.
- R6: A full-word write to 0x8 finds the lowest set bit k of the written data and clears pending bit k. Present bit k is cleared only if slot k is removable. Written data of 0 has no effect.
- R7: Writes to offsets 0x0, 0x4 and 0xC change nothing.
- R8: Event bytes 0 and 1 are status bytes, write-1-to-clear. Bytes 2 and 3 are enable bytes, plain read/write. When a hotplug event and a clear of bit 1 of byte 0 arrive in the same cycle, the bit stays set.
- R9: `evt_out` is 1 exactly while bit 1 of byte 0 and bit 1 of byte 2 are both set.
- R10: A `plat_rst` pulse accepted while idle holds `busy` high for k+2 cycles, where k is the number of pending removals. One pending removal is retired per cycle, lowest slot first. When `busy` falls, pending is 0, removable = ~`fixed_mask` and present = `populated`. Slot requests, eject writes and further `plat_rst` pulses are ignored while `busy` is high.
- R11: A set of a pending or present bit by a slot request wins over an eject that clears the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plat_rst | input | 1 | Platform reset pulse that starts the drain and rebuild sequence |
| ins_req | input | NSLOTS | Per-slot insert events |
| ins_cold | input | NSLOTS | Per-slot flag marking an insert as present at power-up |
| rem_req | input | NSLOTS | Per-slot removal requests |
| fixed_mask | input | NSLOTS | Strap marking non-removable slots |
| populated | input | NSLOTS | Strap marking slots holding a device, used during rebuild |
| reg_sel | input | 1 | Register window access strobe |
| reg_we | input | 1 | Register window write (1) or read (0) |
| reg_addr | input | 4 | Register window byte address |
| reg_be | input | 4 | Register window byte enables |
| reg_wdata | input | NSLOTS | Register window write data |
| reg_rdata | output | NSLOTS | Register window read data, combinational |
| evt_sel | input | 1 | Event block access strobe |
| evt_we | input | 1 | Event block write (1) or read (0) |
| evt_addr | input | 2 | Event block byte address |
| evt_wdata | input | 8 | Event block write byte |
| evt_rdata | output | 8 | Event block read byte, combinational |
| evt_out | output | 1 | Event output |
| slot_present | output | NSLOTS | Present vector |
| busy | output | 1 | Drain or rebuild in progress |

## Verification
Eject writes are tried with several data shapes, and each shape separates a different fault:
- a mask with several bits set exposes a design that retires more than the lowest slot;
- zero data exposes a design that acts on an empty mask;
- a non-removable slot exposes a design that drops the presence of a fixed device.

Hot and cold inserts are issued separately, so a status bit raised by the wrong kind of insert shows up. Same-cycle collisions of set and clear, on both the slot vectors and the status byte, decide the priority order. Drains with three pending removals and with none check that the busy length tracks the pending count. The bench's own model also catches any ordering error in the drain.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic [1:0] {
    PH_RUN     = 2'd0,
    PH_DRAIN   = 2'd1,
    PH_REBUILD = 2'd2
  } hp_phase_e;

  localparam int unsigned REG_WORDS = 4;
  localparam int unsigned REG_AW    = $clog2(REG_WORDS * 4);

  localparam logic [1:0] W_UP    = 2'd0;
  localparam logic [1:0] W_DOWN  = 2'd1;
  localparam logic [1:0] W_EJECT = 2'd2;
  localparam logic [1:0] W_RMV   = 2'd3;

  localparam int unsigned HP_STS_BIT = 1;

  function automatic logic full_word(input logic [3:0] be, input logic [1:0] lo);
    return (be == 4'hF) && (lo == 2'b00);
  endfunction

endpackage

// File: rtl/hp_slot_state.sv
module hp_slot_state
  import hp_pkg::*;
#(
  parameter int unsigned NSLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              plat_rst,
  input  logic [NSLOTS-1:0] ins_req,
  input  logic [NSLOTS-1:0] ins_cold,
  input  logic [NSLOTS-1:0] rem_req,
  input  logic [NSLOTS-1:0] fixed_mask,
  input  logic [NSLOTS-1:0] populated,
  input  logic              ej_wr,
  input  logic [NSLOTS-1:0] ej_data,
  output logic [NSLOTS-1:0] present,
  output logic [NSLOTS-1:0] pending,
  output logic [NSLOTS-1:0] removable,
  output logic              busy,
  output logic              drain_act,
  output logic              rebuild_act,
  output logic              hot_set,
  output logic              ej_fire,
  output logic [NSLOTS-1:0] ej_low
);

  function automatic logic [NSLOTS-1:0] lowest_one(input logic [NSLOTS-1:0] v);
    return v & (~v + NSLOTS'(1));
  endfunction

  hp_phase_e         phase_q, phase_d;
  logic [NSLOTS-1:0] pres_d, pend_d, rmv_d;
  logic [NSLOTS-1:0] drop;
  logic [NSLOTS-1:0] ej_clr;
  logic              run;

  assign run         = (phase_q == PH_RUN);
  assign busy        = !run;
  assign drain_act   = (phase_q == PH_DRAIN);
  assign rebuild_act = (phase_q == PH_REBUILD);

  assign ej_low  = lowest_one(ej_data);
  assign ej_fire = ej_wr && run && (|ej_data);
  assign ej_clr  = ej_fire ? ej_low : '0;
  assign hot_set = run && ((|(ins_req & ~ins_cold)) || (|rem_req));
  assign drop    = lowest_one(pending);

  always_comb begin
    phase_d = phase_q;
    pres_d  = present;
    pend_d  = pending;
    rmv_d   = removable;
    unique case (phase_q)
      PH_RUN: begin
        pend_d = (pending & ~ej_clr) | rem_req;
        pres_d = (present & ~(ej_clr & removable)) | ins_req;
        if (plat_rst) phase_d = PH_DRAIN;
      end
      PH_DRAIN: begin
        if (pending != '0) begin
          pend_d = pending & ~drop;
          pres_d = present & ~(drop & removable);
        end else begin
          phase_d = PH_REBUILD;
        end
      end
      PH_REBUILD: begin
        rmv_d   = ~fixed_mask;
        pres_d  = populated;
        phase_d = PH_RUN;
      end
      default: phase_d = PH_DRAIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_DRAIN;
      present   <= '0;
      pending   <= '0;
      removable <= '0;
    end else begin
      phase_q   <= phase_d;
      present   <= pres_d;
      pending   <= pend_d;
      removable <= rmv_d;
    end
  end

endmodule

// File: rtl/hp_evt_block.sv
module hp_evt_block
  import hp_pkg::*;
#(
  parameter int unsigned EVT_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel,
  input  logic                         we,
  input  logic [$clog2(EVT_BYTES)-1:0] addr,
  input  logic [7:0]                   wdata,
  input  logic                         hot_set,
  output logic [7:0]                   rdata,
  output logic                         evt_out,
  output logic                         sts_hp
);

  localparam int unsigned HALF = EVT_BYTES / 2;
  localparam int unsigned AW   = $clog2(EVT_BYTES);

  logic [7:0] sts_arr [HALF];
  logic [7:0] en_arr  [HALF];
  logic       wr_en;

  assign wr_en = sel && we;

  for (genvar gi = 0; gi < HALF; gi++) begin : g_byte
    localparam bit HAS_HP = (gi == 0);
    logic [7:0] sts_r, sts_nx, en_r;

    always_comb begin
      sts_nx = sts_r;
      if (wr_en && (addr == AW'(gi))) sts_nx = sts_r & ~wdata;
      if (HAS_HP && hot_set) sts_nx[HP_STS_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts_r <= '0;
        en_r  <= '0;
      end else begin
        sts_r <= sts_nx;
        if (wr_en && (addr == AW'(gi + HALF))) en_r <= wdata;
      end
    end

    assign sts_arr[gi] = sts_r;
    assign en_arr[gi]  = en_r;
  end

  always_comb begin
    rdata = '0;
    if (sel && !we) begin
      for (int i = 0; i < HALF; i++) begin
        if (addr == AW'(i))        rdata = sts_arr[i];
        if (addr == AW'(i + HALF)) rdata = en_arr[i];
      end
    end
  end

  assign sts_hp  = sts_arr[0][HP_STS_BIT];
  assign evt_out = sts_arr[0][HP_STS_BIT] & en_arr[0][HP_STS_BIT];

endmodule

// File: rtl/hp_reg_window.sv
module hp_reg_window
  import hp_pkg::*;
#(
  parameter int unsigned NSLOTS = 32
) (
  input  logic              sel,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [3:0]        be,
  input  logic [NSLOTS-1:0] wdata,
  input  logic [NSLOTS-1:0] present,
  input  logic [NSLOTS-1:0] pending,
  input  logic [NSLOTS-1:0] removable,
  output logic [NSLOTS-1:0] rdata,
  output logic              ej_wr,
  output logic [NSLOTS-1:0] ej_data
);

  logic       full;
  logic [1:0] word;

  assign full = full_word(be, addr[1:0]);
  assign word = addr[REG_AW-1:2];

  always_comb begin
    rdata = '0;
    if (sel && !we && full) begin
      unique case (word)
        W_UP:    rdata = present & removable;
        W_DOWN:  rdata = pending;
        W_EJECT: rdata = '0;
        W_RMV:   rdata = removable;
        default: rdata = '0;
      endcase
    end
  end

  assign ej_wr   = sel && we && full && (word == W_EJECT);
  assign ej_data = wdata;

endmodule

// File: rtl/hpslot_evt_ctrl.sv
module hpslot_evt_ctrl
  import hp_pkg::*;
#(
  parameter int unsigned NSLOTS    = 32,
  parameter int unsigned EVT_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         plat_rst,
  input  logic [NSLOTS-1:0]            ins_req,
  input  logic [NSLOTS-1:0]            ins_cold,
  input  logic [NSLOTS-1:0]            rem_req,
  input  logic [NSLOTS-1:0]            fixed_mask,
  input  logic [NSLOTS-1:0]            populated,
  input  logic                         reg_sel,
  input  logic                         reg_we,
  input  logic [3:0]                   reg_addr,
  input  logic [3:0]                   reg_be,
  input  logic [NSLOTS-1:0]            reg_wdata,
  output logic [NSLOTS-1:0]            reg_rdata,
  input  logic                         evt_sel,
  input  logic                         evt_we,
  input  logic [$clog2(EVT_BYTES)-1:0] evt_addr,
  input  logic [7:0]                   evt_wdata,
  output logic [7:0]                   evt_rdata,
  output logic                         evt_out,
  output logic [NSLOTS-1:0]            slot_present,
  output logic                         busy
);

  logic [NSLOTS-1:0] present_v, pending_v, removable_v;
  logic [NSLOTS-1:0] ej_data, ej_low;
  logic              ej_wr, ej_fire, hot_set, sts_hp;
  logic              drain_act, rebuild_act;

  hp_reg_window #(.NSLOTS(NSLOTS)) u_win (
    .sel       (reg_sel),
    .we        (reg_we),
    .addr      (reg_addr),
    .be        (reg_be),
    .wdata     (reg_wdata),
    .present   (present_v),
    .pending   (pending_v),
    .removable (removable_v),
    .rdata     (reg_rdata),
    .ej_wr     (ej_wr),
    .ej_data   (ej_data)
  );

  hp_slot_state #(.NSLOTS(NSLOTS)) u_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .plat_rst    (plat_rst),
    .ins_req     (ins_req),
    .ins_cold    (ins_cold),
    .rem_req     (rem_req),
    .fixed_mask  (fixed_mask),
    .populated   (populated),
    .ej_wr       (ej_wr),
    .ej_data     (ej_data),
    .present     (present_v),
    .pending     (pending_v),
    .removable   (removable_v),
    .busy        (busy),
    .drain_act   (drain_act),
    .rebuild_act (rebuild_act),
    .hot_set     (hot_set),
    .ej_fire     (ej_fire),
    .ej_low      (ej_low)
  );

  hp_evt_block #(.EVT_BYTES(EVT_BYTES)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (evt_sel),
    .we      (evt_we),
    .addr    (evt_addr),
    .wdata   (evt_wdata),
    .hot_set (hot_set),
    .rdata   (evt_rdata),
    .evt_out (evt_out),
    .sts_hp  (sts_hp)
  );

  assign slot_present = present_v;

endmodule

// File: rtl/hp_chk.sv
module hp_chk #(
  parameter int unsigned NSLOTS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hot_set,
  input logic              sts_hp,
  input logic              ej_fire,
  input logic [NSLOTS-1:0] ej_low,
  input logic [NSLOTS-1:0] rem_req,
  input logic [NSLOTS-1:0] pending,
  input logic              busy,
  input logic              drain_act,
  input logic              rebuild_act,
  input logic [NSLOTS-1:0] removable,
  input logic              reg_sel,
  input logic [3:0]        reg_be,
  input logic [NSLOTS-1:0] reg_rdata
);

  p_hot_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hot_set |=> sts_hp)
    else $error("hot event did not set status");

  p_eject_retires_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_fire && ((ej_low & rem_req) == '0)) |=> ((pending & $past(ej_low)) == '0))
    else $error("eject left pending bit set");

  p_no_new_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((pending & ~$past(pending)) == '0))
    else $error("pending grew while busy");

  p_drain_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_act && (pending != '0)) |=> ($countones(pending) == $countones($past(pending)) - 1))
    else $error("drain did not retire exactly one slot");

  p_rmv_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rebuild_act |=> $stable(removable))
    else $error("removable changed outside rebuild");

  p_partial_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && (reg_be != 4'hF)) |-> (reg_rdata == '0))
    else $error("partial access returned data");

endmodule

bind hpslot_evt_ctrl hp_chk #(.NSLOTS(NSLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hot_set     (hot_set),
  .sts_hp      (sts_hp),
  .ej_fire     (ej_fire),
  .ej_low      (ej_low),
  .rem_req     (rem_req),
  .pending     (pending_v),
  .busy        (busy),
  .drain_act   (drain_act),
  .rebuild_act (rebuild_act),
  .removable   (removable_v),
  .reg_sel     (reg_sel),
  .reg_be      (reg_be),
  .reg_rdata   (reg_rdata)
);

// File: tb/sim_hpslot_evt_ctrl.sv
`timescale 1ns/1ps
module sim_hpslot_evt_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        plat_rst = 1'b0;
  logic [31:0] ins_req = '0, ins_cold = '0, rem_req = '0;
  logic [31:0] fixed_mask = 32'h0000_0003, populated = 32'h0000_00F3;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0, reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        evt_sel = 1'b0, evt_we = 1'b0;
  logic [1:0]  evt_addr = '0;
  logic [7:0]  evt_wdata = '0;
  logic [7:0]  evt_rdata;
  logic        evt_out, busy;
  logic [31:0] slot_present;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hpslot_evt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .plat_rst(plat_rst),
    .ins_req(ins_req), .ins_cold(ins_cold), .rem_req(rem_req),
    .fixed_mask(fixed_mask), .populated(populated),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_sel(evt_sel), .evt_we(evt_we), .evt_addr(evt_addr), .evt_wdata(evt_wdata),
    .evt_rdata(evt_rdata), .evt_out(evt_out), .slot_present(slot_present), .busy(busy)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_pres, m_pend, m_rmv;
  logic [7:0]  m_sts [2];
  logic [7:0]  m_en  [2];
  int          m_phase;   // 0 idle, 1 draining, 2 rebuilding
  int          m_q [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pres = 0; m_pend = 0; m_rmv = 0;
      m_sts[0] = 0; m_sts[1] = 0; m_en[0] = 0; m_en[1] = 0;
      m_phase = 1; m_q.delete();
    end else begin
      bit hot;
      hot = 0;
      if (m_phase == 0) begin
        hot = ((ins_req & ~ins_cold) != 0) || (rem_req != 0);
        if (reg_sel && reg_we && reg_be == 4'hF && reg_addr == 4'h8 && reg_wdata != 0) begin
          int k;
          k = 0;
          while (!reg_wdata[k]) k++;
          m_pend[k] = 1'b0;
          if (m_rmv[k]) m_pres[k] = 1'b0;
        end
        m_pend = m_pend | rem_req;
        m_pres = m_pres | ins_req;
        if (plat_rst) begin
          m_phase = 1;
          for (int i = 0; i < 32; i++) if (m_pend[i]) m_q.push_back(i);
        end
      end else if (m_phase == 1) begin
        if (m_q.size() > 0) begin
          int k;
          k = m_q.pop_front();
          m_pend[k] = 1'b0;
          if (m_rmv[k]) m_pres[k] = 1'b0;
        end else m_phase = 2;
      end else begin
        m_rmv = ~fixed_mask;
        m_pres = populated;
        m_phase = 0;
      end
      if (evt_sel && evt_we) begin
        if (evt_addr < 2) m_sts[evt_addr] = m_sts[evt_addr] & ~evt_wdata;
        else m_en[evt_addr - 2] = evt_wdata;
      end
      if (hot) m_sts[0][1] = 1'b1;
    end
  end

  function automatic logic [31:0] exp_reg();
    if (!(reg_sel && !reg_we && reg_be == 4'hF && reg_addr[1:0] == 2'b00)) return 0;
    case (reg_addr)
      4'h0: return m_pres & m_rmv;
      4'h4: return m_pend;
      4'hC: return m_rmv;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_evt();
    if (!(evt_sel && !evt_we)) return 0;
    return (evt_addr < 2) ? m_sts[evt_addr] : m_en[evt_addr - 2];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 model reg_rdata", reg_rdata, exp_reg());
      chk("R8 model evt_rdata", {24'd0, evt_rdata}, {24'd0, exp_evt()});
      chk("R9 model evt_out", {31'd0, evt_out}, {31'd0, m_sts[0][1] & m_en[0][1]});
      chk("R10 model busy", {31'd0, busy}, {31'd0, m_phase != 0});
      chk("R4 model slot_present", slot_present, m_pres);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd32(input logic [3:0] a, input logic [3:0] be, output logic [31:0] v);
    reg_sel = 1; reg_we = 0; reg_addr = a; reg_be = be;
    @(negedge clk); v = reg_rdata;
    tick(); reg_sel = 0;
  endtask

  task automatic wr32(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    reg_sel = 1; reg_we = 1; reg_addr = a; reg_be = be; reg_wdata = d;
    tick(); reg_sel = 0; reg_we = 0;
  endtask

  task automatic evrd(input logic [1:0] a, output logic [7:0] v);
    evt_sel = 1; evt_we = 0; evt_addr = a;
    @(negedge clk); v = evt_rdata;
    tick(); evt_sel = 0;
  endtask

  task automatic evwr(input logic [1:0] a, input logic [7:0] d);
    evt_sel = 1; evt_we = 1; evt_addr = a; evt_wdata = d;
    tick(); evt_sel = 0; evt_we = 0;
  endtask

  task automatic ins(input logic [31:0] v, input logic [31:0] cold);
    ins_req = v; ins_cold = cold;
    tick(); ins_req = 0; ins_cold = 0;
  endtask

  task automatic rem(input logic [31:0] v);
    rem_req = v;
    tick(); rem_req = 0;
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] v;
    logic [7:0]  b;
    int cnt;

    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 busy right after reset", {31'd0, busy}, 32'd1);
    tick(); tick();
    chk("R1 busy low after 2 cycles", {31'd0, busy}, 32'd0);
    rd32(4'h0, 4'hF, v); chk("R1 up after reset", v, 32'h0000_00F0);
    rd32(4'h4, 4'hF, v); chk("R1 down after reset", v, 32'h0);
    rd32(4'hC, 4'hF, v); chk("R1 removable after reset", v, 32'hFFFF_FFFC);
    rd32(4'h8, 4'hF, v); chk("R2 eject offset reads zero", v, 32'h0);
    evrd(2'd0, b); chk("R1 status byte after reset", {24'd0, b}, 32'h0);
    chk("R1 evt_out after reset", {31'd0, evt_out}, 32'd0);

    // R4 hot and cold inserts
    ins(32'h100, 32'h0);
    rd32(4'h0, 4'hF, v); chk("R4 hot insert sets up bit", v, 32'h0000_01F0);
    evrd(2'd0, b); chk("R4 hot insert sets status", {24'd0, b}, 32'h02);
    evwr(2'd0, 8'h02);
    evrd(2'd0, b); chk("R8 status write-1-to-clear", {24'd0, b}, 32'h00);
    ins(32'h200, 32'h200);
    rd32(4'h0, 4'hF, v); chk("R4 cold insert sets up bit", v, 32'h0000_03F0);
    evrd(2'd0, b); chk("R4 cold insert no status", {24'd0, b}, 32'h00);

    // R9 / R8 event output and byte map
    evwr(2'd2, 8'h02);
    chk("R9 enable alone no event", {31'd0, evt_out}, 32'd0);
    evrd(2'd2, b); chk("R8 enable byte readback", {24'd0, b}, 32'h02);
    ins(32'h400, 32'h0);
    chk("R9 status and enable raise event", {31'd0, evt_out}, 32'd1);
    evwr(2'd0, 8'h02);
    chk("R9 clearing status drops event", {31'd0, evt_out}, 32'd0);
    evwr(2'd1, 8'hFF);
    evrd(2'd1, b); chk("R8 status byte 1 stays clear", {24'd0, b}, 32'h00);
    evwr(2'd3, 8'hA5);
    evrd(2'd3, b); chk("R8 enable byte 3 read/write", {24'd0, b}, 32'hA5);

    // R5 removal requests
    rem(32'h50);
    rd32(4'h4, 4'hF, v); chk("R5 down after removal requests", v, 32'h50);
    chk("R5 removal raises event", {31'd0, evt_out}, 32'd1);

    // R6 eject
    wr32(4'h8, 4'hF, 32'h50);
    rd32(4'h4, 4'hF, v); chk("R6 eject retires lowest only", v, 32'h40);
    rd32(4'h0, 4'hF, v); chk("R6 eject clears present of removable", v, 32'h0000_07E0);
    wr32(4'h8, 4'hF, 32'h0);
    rd32(4'h4, 4'hF, v); chk("R6 eject of zero no effect", v, 32'h40);
    rem(32'h2);
    wr32(4'h8, 4'hF, 32'h2);
    rd32(4'h4, 4'hF, v); chk("R6 eject fixed slot clears pending", v, 32'h40);
    chk("R6 fixed slot keeps present", slot_present, 32'h0000_07E3);

    // R3 partial / misaligned
    wr32(4'h8, 4'h3, 32'h40);
    rd32(4'h4, 4'hF, v); chk("R3 partial write ignored", v, 32'h40);
    rd32(4'h4, 4'h1, v); chk("R3 partial read returns zero", v, 32'h0);
    rd32(4'h5, 4'hF, v); chk("R3 misaligned read returns zero", v, 32'h0);

    // R7 writes to other offsets
    wr32(4'h0, 4'hF, 32'hFFFF_FFFF);
    wr32(4'h4, 4'hF, 32'hFFFF_FFFF);
    wr32(4'hC, 4'hF, 32'h0);
    rd32(4'h0, 4'hF, v); chk("R7 up unchanged", v, 32'h0000_07E0);
    rd32(4'h4, 4'hF, v); chk("R7 down unchanged", v, 32'h40);
    rd32(4'hC, 4'hF, v); chk("R7 removable unchanged", v, 32'hFFFF_FFFC);

    // R11 / R8 same-cycle collisions
    reg_sel = 1; reg_we = 1; reg_addr = 4'h8; reg_be = 4'hF; reg_wdata = 32'h10;
    rem_req = 32'h10; ins_req = 32'h10;
    evt_sel = 1; evt_we = 1; evt_addr = 2'd0; evt_wdata = 8'h02;
    tick();
    reg_sel = 0; reg_we = 0; rem_req = 0; ins_req = 0; evt_sel = 0; evt_we = 0;
    rd32(4'h4, 4'hF, v); chk("R11 request beats eject on pending", v, 32'h50);
    rd32(4'h0, 4'hF, v); chk("R11 insert beats eject on present", v, 32'h0000_07F0);
    evrd(2'd0, b); chk("R8 set beats same-cycle clear", {24'd0, b}, 32'h02);

    // R10 drain with three pending removals
    rem(32'h1000);
    fixed_mask = 32'h0000_0013;
    plat_rst = 1; tick(); plat_rst = 0;
    cnt = 0;
    ins_req = 32'h0010_0000;
    reg_sel = 1; reg_we = 1; reg_addr = 4'h8; reg_be = 4'hF; reg_wdata = 32'h1000;
    plat_rst = 1;
    @(negedge clk); if (busy) cnt++;
    tick();
    ins_req = 0; reg_sel = 0; reg_we = 0; plat_rst = 0;
    @(negedge clk);
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    tick();
    chk("R10 busy length with 3 pending", cnt, 32'd5);
    rd32(4'h4, 4'hF, v); chk("R10 down empty after drain", v, 32'h0);
    rd32(4'hC, 4'hF, v); chk("R10 removable rebuilt", v, 32'hFFFF_FFEC);
    chk("R10 present rebuilt, busy insert ignored", slot_present, 32'h0000_00F3);
    rd32(4'h0, 4'hF, v); chk("R10 up after rebuild", v, 32'h0000_00E0);

    // R10 drain with nothing pending
    plat_rst = 1; tick(); plat_rst = 0;
    cnt = 0;
    @(negedge clk);
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    tick();
    chk("R10 busy length with 0 pending", cnt, 32'd2);

    repeat (4) tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule